// File: doc/BRIEF.md
# Dual-Bank Integer-N Synthesizer Divider Controller

This block holds the digital dividers of an integer-N frequency synthesizer. A reference divider counts crystal-clock cycles and emits one pulse every R+1 cycles. A feedback divider counts VCO-clock cycles through a 75/76 dual-modulus prescaler model with swallow counting, and emits one pulse every 75*(P+1)+S cycles. Both pulse trains go to an external phase detector. The VCO, charge pump, loop filter and crystal oscillator are outside the block.

Software programs two complete ratio banks through a small register port. A select bit chooses which bank drives the dividers. Software can load the idle bank while the other is in use, then flip the select bit to hop to the new channel. A ratio change takes effect only at a divider terminal count, so no period is ever cut short. A bank that breaks the range rules is still stored, but a sticky flag is raised and the dividers keep the last legal ratio. An external lock-detect level is synchronized and then drives an optional lock pin and a sticky lock flag that is cleared by writing a one.

Top module: `pll_divctl`

## Requirements
- R1: `ref_pulse` is high for one `xtal_clk` cycle, once every R+1 `xtal_clk` cycles, where R is the active ratio.
- R2: `fb_pulse` is high for one `vco_clk` cycle, once every 75*(P+1)+S `vco_clk` cycles.
- R3: A bank is legal when 64 <= R <= 169 and S <= P. While the selected bank is illegal, the dividers keep the last legal ratio.
- R4: The bank registers sit at `reg_addr` = {0, bank, field}: bit 2 is the bank, and bits 1:0 are the field (0 = R, 1 = P, 2 = S). Every write, legal or not, is stored and reads back on `reg_rdata`.
- R5: Control address 8, bit 0, selects the active bank. Writing the idle bank leaves the output periods unchanged.
- R6: After the select bit toggles, every feedback period is either the complete old ratio or the complete new ratio, and the new ratio follows within a few periods.
- R7: Control address 8, bit 1, enables the lock pin (reset value 1). When it is enabled, `lock_pin` follows `lock_det` after a two-flop synchronizer. When it is cleared, `lock_pin` is low.
- R8: Status address 9, bit 0, is set on each rising edge of the synchronized `lock_det`. It holds until a write with bit 0 equal to 1. Writing 0 to that bit has no effect.
- R9: Status address 9, bit 1, is set by any bank write that leaves that bank illegal. It holds until a write with bit 1 equal to 1.
- R10: After reset, both banks hold R=64, P=0, S=0, the select bit is 0, lock enable is 1 and both status bits are 0. The reference period is then 65 and the feedback period is 75.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Register-port clock |
| rst_n | input | 1 | Asynchronous active-low reset for all domains |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 4 | Register address |
| reg_wdata | input | 8 | Register write data |
| reg_rdata | output | 8 | Register read data for `reg_addr` |
| xtal_clk | input | 1 | Crystal reference clock |
| vco_clk | input | 1 | VCO clock |
| lock_det | input | 1 | Asynchronous lock-detect level |
| ref_pulse | output | 1 | Divided reference pulse (`xtal_clk` domain) |
| fb_pulse | output | 1 | Divided feedback pulse (`vco_clk` domain) |
| lock_pin | output | 1 | Gated, synchronized lock indication |

## Verification
The hardest case to reach is a select-bit toggle that lands in the middle of a feedback period, after the ratio has crossed two clock domains. The stimulus first programs the idle bank to a period quite different from the active one, then flips the select bit at an arbitrary phase. It measures every feedback period that follows, and requires each one to be exactly the old ratio or exactly the new one, ending on the new one. Illegal banks are reached by writing an out-of-range R into the active bank. The bench then confirms that the reference period stays where it was until a legal R is written.

// File: rtl/pll_divctl_pkg.sv
package pll_divctl_pkg;
  localparam int DIV_W   = 8;
  localparam int PRESC   = 75;
  localparam int R_MIN   = 64;
  localparam int R_MAX   = 169;
  localparam int PROG_W  = DIV_W + 1;
  localparam int PER_W   = 16;

  typedef struct packed {
    logic [DIV_W-1:0] r;
    logic [DIV_W-1:0] p;
    logic [DIV_W-1:0] s;
  } ratio_t;

  localparam ratio_t RATIO_RST = '{r: 8'd64, p: 8'd0, s: 8'd0};

  // Legality of a ratio set: R inside its window, swallow count not above P.
  function automatic logic ratio_ok(input ratio_t x);
    return (int'(x.r) >= R_MIN) && (int'(x.r) <= R_MAX) && (x.s <= x.p);
  endfunction

  // Number of prescaler cycles per feedback period (P+1).
  function automatic logic [PROG_W-1:0] prog_load(input logic [DIV_W-1:0] p);
    return {1'b0, p} + PROG_W'(1);
  endfunction

  // Feedback divide ratio in VCO cycles.
  function automatic logic [PER_W-1:0] fb_modulus(input logic [DIV_W-1:0] p,
                                                  input logic [DIV_W-1:0] s);
    return PER_W'(PRESC) * PER_W'(prog_load(p)) + PER_W'(s);
  endfunction
endpackage

// File: rtl/pll_divctl_regs.sv
module pll_divctl_regs
  import pll_divctl_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       reg_wr,
  input  logic [3:0] reg_addr,
  input  logic [7:0] reg_wdata,
  output logic [7:0] reg_rdata,
  input  logic       lock_raw,
  output logic       lock_pin,
  output ratio_t     eff
);
  localparam logic [3:0] ADDR_CTRL = 4'd8;
  localparam logic [3:0] ADDR_STAT = 4'd9;

  logic   sel_q, lock_en_q, lock_flag_q, inv_flag_q;
  logic   ls1, ls2, ls3;
  ratio_t bank_cur [2];
  ratio_t wr_next;
  logic   bank_hit, ctrl_wr, stat_wr, lock_rise, bad_write;

  assign bank_hit = reg_wr && !reg_addr[3] && (reg_addr[1:0] != 2'd3);
  assign ctrl_wr  = reg_wr && (reg_addr == ADDR_CTRL);
  assign stat_wr  = reg_wr && (reg_addr == ADDR_STAT);

  // Content a bank write would leave in the addressed bank.
  always_comb begin
    wr_next = bank_cur[reg_addr[2]];
    case (reg_addr[1:0])
      2'd0:    wr_next.r = reg_wdata;
      2'd1:    wr_next.p = reg_wdata;
      2'd2:    wr_next.s = reg_wdata;
      default: ;
    endcase
  end
  assign bad_write = bank_hit && !ratio_ok(wr_next);

  for (genvar b = 0; b < 2; b++) begin : g_bank
    ratio_t q;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                               q <= RATIO_RST;
      else if (bank_hit && reg_addr[2] == b[0]) q <= wr_next;
    end
    assign bank_cur[b] = q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sel_q <= 1'b0;
      lock_en_q <= 1'b1;
    end else if (ctrl_wr) begin
      sel_q <= reg_wdata[0];
      lock_en_q <= reg_wdata[1];
    end
  end

  // Last legal ratio of the selected bank.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                        eff <= RATIO_RST;
    else if (ratio_ok(bank_cur[sel_q])) eff <= bank_cur[sel_q];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) {ls1, ls2, ls3} <= '0;
    else        {ls1, ls2, ls3} <= {lock_raw, ls1, ls2};
  end
  assign lock_rise = ls2 && !ls3;
  assign lock_pin  = lock_en_q && ls2;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lock_flag_q <= 1'b0;
      inv_flag_q  <= 1'b0;
    end else begin
      if (lock_rise)                       lock_flag_q <= 1'b1;
      else if (stat_wr && reg_wdata[0])    lock_flag_q <= 1'b0;
      if (bad_write)                       inv_flag_q  <= 1'b1;
      else if (stat_wr && reg_wdata[1])    inv_flag_q  <= 1'b0;
    end
  end

  always_comb begin
    reg_rdata = '0;
    if (!reg_addr[3]) begin
      case (reg_addr[1:0])
        2'd0:    reg_rdata = bank_cur[reg_addr[2]].r;
        2'd1:    reg_rdata = bank_cur[reg_addr[2]].p;
        2'd2:    reg_rdata = bank_cur[reg_addr[2]].s;
        default: reg_rdata = '0;
      endcase
    end else if (reg_addr == ADDR_CTRL) reg_rdata = {6'd0, lock_en_q, sel_q};
    else if (reg_addr == ADDR_STAT)     reg_rdata = {6'd0, inv_flag_q, lock_flag_q};
  end

  AST_EFF_LEGAL: assert property (@(posedge clk) disable iff (!rst_n)
    ratio_ok(eff)); // R3
  AST_LOCK_SETS: assert property (@(posedge clk) disable iff (!rst_n)
    lock_rise |=> lock_flag_q); // R8
  AST_LOCK_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    lock_flag_q && !(stat_wr && reg_wdata[0]) |=> lock_flag_q); // R8
  AST_INV_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    inv_flag_q && !(stat_wr && reg_wdata[1]) |=> inv_flag_q); // R9
  AST_PIN_GATED: assert property (@(posedge clk) disable iff (!rst_n)
    lock_pin |-> lock_en_q); // R7
endmodule

// File: rtl/pll_ratio_cdc.sv
module pll_ratio_cdc
  import pll_divctl_pkg::*;
(
  input  logic   src_clk,
  input  logic   src_rst_n,
  input  ratio_t src_data,
  input  logic   dst_clk,
  input  logic   dst_rst_n,
  output ratio_t dst_data
);
  ratio_t held;
  logic   tog;
  logic   t1, t2, t3;

  always_ff @(posedge src_clk or negedge src_rst_n) begin
    if (!src_rst_n) begin
      held <= RATIO_RST;
      tog  <= 1'b0;
    end else if (src_data != held) begin
      held <= src_data;
      tog  <= ~tog;
    end
  end

  always_ff @(posedge dst_clk or negedge dst_rst_n) begin
    if (!dst_rst_n) begin
      {t1, t2, t3} <= '0;
      dst_data     <= RATIO_RST;
    end else begin
      {t1, t2, t3} <= {tog, t1, t2};
      if (t2 != t3) dst_data <= held;
    end
  end
endmodule

// File: rtl/pll_ref_div.sv
module pll_ref_div
  import pll_divctl_pkg::*;
(
  input  logic   xtal_clk,
  input  logic   rst_n,
  input  ratio_t nxt,
  output logic   ref_pulse
);
  logic [DIV_W-1:0] cnt, cur_r;
  logic tc;

  assign tc = (cnt == cur_r);

  always_ff @(posedge xtal_clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt <= '0;
      cur_r <= RATIO_RST.r;
      ref_pulse <= 1'b0;
    end else begin
      ref_pulse <= tc;
      if (tc) begin
        cnt <= '0;
        cur_r <= nxt.r;
      end else begin
        cnt <= cnt + 1'b1;
      end
    end
  end

  AST_REF_BOUND: assert property (@(posedge xtal_clk) disable iff (!rst_n)
    cnt <= cur_r); // R1
  AST_REF_NARROW: assert property (@(posedge xtal_clk) disable iff (!rst_n)
    ref_pulse |=> !ref_pulse); // R1
endmodule

// File: rtl/pll_fb_div.sv
module pll_fb_div
  import pll_divctl_pkg::*;
(
  input  logic   vco_clk,
  input  logic   rst_n,
  input  ratio_t nxt,
  output logic   fb_pulse
);
  localparam int PC_W = $clog2(PRESC + 1);

  logic [PC_W-1:0]   pre_cnt;
  logic [PROG_W-1:0] prog_left;
  logic [DIV_W-1:0]  swl;
  logic [PER_W-1:0]  per_cnt;
  ratio_t            cur;
  logic pre_last, tc;

  // Prescaler divides by 76 while swallow cycles remain, else by 75.
  assign pre_last = (pre_cnt == ((swl != '0) ? PC_W'(PRESC) : PC_W'(PRESC - 1)));
  assign tc       = pre_last && (prog_left == PROG_W'(1));

  always_ff @(posedge vco_clk or negedge rst_n) begin
    if (!rst_n) begin
      pre_cnt   <= '0;
      prog_left <= prog_load(RATIO_RST.p);
      swl       <= RATIO_RST.s;
      cur       <= RATIO_RST;
      per_cnt   <= '0;
      fb_pulse  <= 1'b0;
    end else begin
      fb_pulse <= tc;
      per_cnt  <= tc ? '0 : per_cnt + 1'b1;
      if (pre_last) begin
        pre_cnt <= '0;
        if (tc) begin
          prog_left <= prog_load(nxt.p);
          swl       <= nxt.s;
          cur       <= nxt;
        end else begin
          prog_left <= prog_left - 1'b1;
          if (swl != '0) swl <= swl - 1'b1;
        end
      end else begin
        pre_cnt <= pre_cnt + 1'b1;
      end
    end
  end

  AST_SWALLOW_BELOW_PROG: assert property (@(posedge vco_clk) disable iff (!rst_n)
    {1'b0, swl} < prog_left); // R2
  AST_FB_PERIOD: assert property (@(posedge vco_clk) disable iff (!rst_n)
    tc |-> (per_cnt + 1'b1 == fb_modulus(cur.p, cur.s))); // R2
  AST_FB_NARROW: assert property (@(posedge vco_clk) disable iff (!rst_n)
    fb_pulse |=> !fb_pulse); // R6
endmodule

// File: rtl/pll_divctl.sv
module pll_divctl
  import pll_divctl_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       reg_wr,
  input  logic [3:0] reg_addr,
  input  logic [7:0] reg_wdata,
  output logic [7:0] reg_rdata,
  input  logic       xtal_clk,
  input  logic       vco_clk,
  input  logic       lock_det,
  output logic       ref_pulse,
  output logic       fb_pulse,
  output logic       lock_pin
);
  ratio_t eff, ref_nxt, fb_nxt;
  logic [1:0] xr_q, vr_q;
  logic xtal_rst_n, vco_rst_n;

  always_ff @(posedge xtal_clk or negedge rst_n) begin
    if (!rst_n) xr_q <= '0;
    else        xr_q <= {xr_q[0], 1'b1};
  end
  always_ff @(posedge vco_clk or negedge rst_n) begin
    if (!rst_n) vr_q <= '0;
    else        vr_q <= {vr_q[0], 1'b1};
  end
  assign xtal_rst_n = xr_q[1];
  assign vco_rst_n  = vr_q[1];

  pll_divctl_regs u_regs (
    .clk, .rst_n, .reg_wr, .reg_addr, .reg_wdata, .reg_rdata,
    .lock_raw(lock_det), .lock_pin, .eff
  );

  pll_ratio_cdc u_cdc_ref (
    .src_clk(clk), .src_rst_n(rst_n), .src_data(eff),
    .dst_clk(xtal_clk), .dst_rst_n(xtal_rst_n), .dst_data(ref_nxt)
  );

  pll_ratio_cdc u_cdc_fb (
    .src_clk(clk), .src_rst_n(rst_n), .src_data(eff),
    .dst_clk(vco_clk), .dst_rst_n(vco_rst_n), .dst_data(fb_nxt)
  );

  pll_ref_div u_ref (
    .xtal_clk, .rst_n(xtal_rst_n), .nxt(ref_nxt), .ref_pulse
  );

  pll_fb_div u_fb (
    .vco_clk, .rst_n(vco_rst_n), .nxt(fb_nxt), .fb_pulse
  );
endmodule

// File: tb/tb_pll_divctl.sv
module tb_pll_divctl;
  logic clk = 0, xtal_clk = 0, vco_clk = 0;
  logic rst_n = 0;
  logic reg_wr = 0;
  logic [3:0] reg_addr = '0;
  logic [7:0] reg_wdata = '0;
  logic [7:0] reg_rdata;
  logic lock_det = 0;
  logic ref_pulse, fb_pulse, lock_pin;

  int checks = 0, failures = 0;
  int fb_n = 0, fb_per = 0, fb_cnt = 0;
  int ref_n = 0, ref_per = 0, ref_cnt = 0;

  always #2 clk = ~clk;
  always #5 xtal_clk = ~xtal_clk;
  always #1 vco_clk = ~vco_clk;

  pll_divctl dut (.*);

  always @(negedge vco_clk) begin
    fb_cnt = fb_cnt + 1;
    if (fb_pulse) begin fb_per = fb_cnt; fb_cnt = 0; fb_n = fb_n + 1; end
  end
  always @(negedge xtal_clk) begin
    ref_cnt = ref_cnt + 1;
    if (ref_pulse) begin ref_per = ref_cnt; ref_cnt = 0; ref_n = ref_n + 1; end
  end

  function automatic int fb_expect(int p, int s);
    return p * 75 + 75 + s;
  endfunction

  task automatic chk(string req, int act, int exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic wr(int a, int d);
    @(negedge clk);
    reg_wr = 1; reg_addr = 4'(a); reg_wdata = 8'(d);
    @(negedge clk);
    reg_wr = 0;
  endtask

  task automatic rd(int a, output int d);
    @(negedge clk);
    reg_addr = 4'(a);
    #1 d = int'(reg_rdata);
  endtask

  task automatic wait_fb(int n);
    int s = fb_n;
    wait (fb_n >= s + n);
  endtask
  task automatic wait_ref(int n);
    int s = ref_n;
    wait (ref_n >= s + n);
  endtask

  task automatic t_reset;
    int d;
    rd(0, d); chk("R10 bank0 R", d, 64);
    rd(5, d); chk("R10 bank1 P", d, 0);
    rd(8, d); chk("R10 ctrl", d, 2);
    rd(9, d); chk("R10 status", d, 0);
    wait_fb(3);  chk("R10 fb period", fb_per, 75);
    wait_ref(3); chk("R10 ref period", ref_per, 65);
    chk("R7 pin low when unlocked", int'(lock_pin), 0);
  endtask

  task automatic t_ratios;
    int d;
    wr(0, 100); wr(1, 2); wr(2, 1);
    rd(0, d); chk("R4 bank0 R readback", d, 100);
    rd(2, d); chk("R4 bank0 S readback", d, 1);
    wait_ref(3); chk("R1 ref period R=100", ref_per, 101);
    wait_fb(3);  chk("R2 fb period P=2 S=1", fb_per, fb_expect(2, 1));
    wr(1, 3); wr(2, 3);
    wait_fb(3);  chk("R2 fb period P=3 S=3", fb_per, fb_expect(3, 3));
    wr(2, 0);
    wait_fb(3);  chk("R2 fb period P=3 S=0", fb_per, fb_expect(3, 0));
  endtask

  task automatic t_idle_bank;
    int d;
    wr(4, 169); wr(5, 0); wr(6, 0);
    rd(4, d); chk("R4 bank1 R readback", d, 169);
    wait_fb(3);  chk("R5 idle write keeps fb", fb_per, fb_expect(3, 0));
    wait_ref(2); chk("R5 idle write keeps ref", ref_per, 101);
  endtask

  task automatic t_hop(int sel, int old_p, int new_p);
    int e_old = fb_expect(old_p, 0), e_new = fb_expect(new_p, 0);
    wait_fb(1);
    repeat (17) @(negedge vco_clk);
    wr(8, 2 | sel);
    for (int i = 0; i < 5; i++) begin
      wait_fb(1);
      checks++;
      if (fb_per != e_old && fb_per != e_new) begin
        failures++;
        $display("FAIL R6 hop period actual=%0d expected=%0d or %0d", fb_per, e_old, e_new);
      end
    end
    chk("R6 hop lands on new ratio", fb_per, e_new);
  endtask

  task automatic t_invalid;
    int d;
    wr(4, 20);
    rd(4, d); chk("R4 illegal R stored", d, 20);
    rd(9, d); chk("R9 invalid flag set", (d >> 1) & 1, 1);
    wait_ref(3); chk("R3 ref keeps legal ratio", ref_per, 170);
    wr(9, 1);
    rd(9, d); chk("R9 bit0 write keeps invalid", (d >> 1) & 1, 1);
    wr(9, 2);
    rd(9, d); chk("R9 invalid flag cleared", (d >> 1) & 1, 0);
    wr(5, 1); wr(6, 2);
    wr(4, 80);
    rd(9, d); chk("R3 S>P flags invalid", (d >> 1) & 1, 1);
    wait_ref(3); chk("R3 ref held while S>P", ref_per, 170);
    wr(6, 1);
    wait_ref(3); chk("R3 legal again R=80", ref_per, 81);
    wait_fb(3);  chk("R2 fb P=1 S=1", fb_per, fb_expect(1, 1));
    wr(9, 2);
  endtask

  task automatic t_lock;
    int d;
    lock_det = 1;
    repeat (4) @(negedge clk);
    chk("R7 pin follows lock", int'(lock_pin), 1);
    rd(9, d); chk("R8 lock flag set", d & 1, 1);
    lock_det = 0;
    repeat (4) @(negedge clk);
    chk("R7 pin drops", int'(lock_pin), 0);
    rd(9, d); chk("R8 flag sticky", d & 1, 1);
    wr(9, 0);
    rd(9, d); chk("R8 write 0 no effect", d & 1, 1);
    wr(9, 1);
    rd(9, d); chk("R8 flag cleared", d & 1, 0);
    wr(8, 1);
    lock_det = 1;
    repeat (4) @(negedge clk);
    chk("R7 pin low when disabled", int'(lock_pin), 0);
    rd(9, d); chk("R8 set while pin disabled", d & 1, 1);
    wr(8, 3);
    repeat (2) @(negedge clk);
    chk("R7 pin after re-enable", int'(lock_pin), 1);
  endtask

  initial begin
    repeat (5) @(negedge clk);
    rst_n = 1;
    repeat (5) @(negedge clk);
    t_reset();
    t_ratios();
    t_idle_bank();
    wr(0, 100); wr(1, 3); wr(2, 0);
    wr(5, 1);
    wait_fb(3);
    t_hop(1, 3, 1);
    t_hop(0, 1, 3);
    wr(8, 3);
    wait_ref(3); chk("R5 bank1 drives ref", ref_per, 170);
    t_invalid();
    t_lock();
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    checks++; failures++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule